// File: doc/BRIEF.md
# Cascaded Second-Level Interrupt Aggregator

This block sits between a group of peripheral interrupt lines and a parent interrupt controller. It takes up to 32 level-sensitive source lines and merges them onto a small number of parent lines. Each merged parent line has a fixed selection mask. The line is high while any selected source is both pending and enabled. A second fixed mask marks sources that skip the merging step. Each of those sources drives a dedicated parent line of its own, at the same bit position. Those sources are invisible to the merged lines and to the wake request.

Software reaches two 32-bit registers through a simple select/write register bus. An enable register at byte offset 0x0 gates the merged sources. A read-only status register at byte offset 0x4 shows the raw source levels. A wake request is the OR of every enabled, merged source. It can be compiled out with a parameter. All parent-facing outputs are registered once and are level-sensitive.

The register bus has no back-pressure and always accepts an access in the cycle it is presented. None of the pins carry a data stream, so there is no valid/ready pair. The read-valid strobe marks the cycle that carries read data.

Top module: `l2_irq_aggregator`

## Requirements
- R1: A source position that is in no selection mask and not in the forward mask is unwired. It never raises any output, and it reads 0 in both the status register and the enable register.
- R2: In the cycle after the inputs are sampled, merged output k (`agg_irq_o[k]`) is high exactly when some source is high, enabled, selected by mask k, and not forwarded.
- R3: A forwarded source i drives `fwd_irq_o[i]` one cycle after it is sampled, whatever its enable bit holds. Every `fwd_irq_o` bit outside the forward mask stays 0.
- R4: A forwarded source never affects any merged output or the wake request, even when its bit also appears in a selection mask.
- R5: A write with `reg_addr_i[2]`=0 loads the enable register. A read with `reg_addr_i[2]`=0 returns it. Only wired positions are stored, and the register clears to 0 on reset.
- R6: A read with `reg_addr_i[2]`=1 returns the source levels sampled in the read cycle, with unwired bits as 0. A write to that address changes no state.
- R7: `reg_rvalid_o` is high for exactly one cycle after each read request (`reg_sel_i`=1, `reg_wr_i`=0), and at no other time. `reg_rdata_o` carries the read data in that same cycle.
- R8: With WAKE_EN=1, `wake_o` goes high one cycle after any enabled, wired, non-forwarded source is high, and is 0 otherwise. With WAKE_EN=0 it stays 0.
- R9: A merged output drops in the cycle after its last contributing source falls. It also drops in the cycle after the write that disables that source takes effect. Remaining contributors keep it high.
- R10: Reset (`rst_i`=1, synchronous) clears every output and the enable register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| src_i | input | SRC_W | Level-sensitive interrupt sources |
| reg_sel_i | input | 1 | Register access request |
| reg_wr_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 3 | Byte address in the 8-byte window; bit 2 picks the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid with reg_rvalid_o |
| reg_rvalid_o | output | 1 | Read data strobe, one cycle after a read request |
| agg_irq_o | output | NUM_AGG | Merged parent interrupt lines |
| fwd_irq_o | output | SRC_W | Direct parent lines for forwarded sources |
| wake_o | output | 1 | Combined wake request |

## Verification
The bench builds the block with 32 sources, two merged outputs and the forward mask 0x7. The selection masks are 0xEB8 and 0x141, and WAKE_EN=1. Source 0 therefore appears in the second selection mask while also being forwarded. This makes the rule that a forwarded source is invisible to merging observable at the ports. The masks leave positions 12 to 31 unwired, so the bench can drive every unwired source high at once and check that all outputs and both registers stay quiet.

// File: rtl/l2irq_pkg.sv
package l2irq_pkg;

  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;

  // Register picked by byte-address bit 2
  typedef enum logic {
    REG_ENABLE = 1'b0,
    REG_STATUS = 1'b1
  } reg_pick_e;

  // Positions that reach some parent output
  function automatic logic [REG_W-1:0] wired_union(
      input logic [7:0][REG_W-1:0] masks,
      input int unsigned           count,
      input logic [REG_W-1:0]      fwd);
    logic [REG_W-1:0] acc;
    acc = fwd;
    for (int unsigned k = 0; k < 8; k++) begin
      if (k < count) acc = acc | masks[k];
    end
    return acc;
  endfunction

endpackage

// File: rtl/l2irq_regs.sv
module l2irq_regs
  import l2irq_pkg::*;
#(
  parameter int unsigned      SRC_W     = 32,
  parameter logic [SRC_W-1:0] KEEP_MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [SRC_W-1:0]  src_i,
  output logic [SRC_W-1:0]  en_o,
  output logic [REG_W-1:0]  rdata_o,
  output logic              rvalid_o
);

  reg_pick_e        pick;
  logic [SRC_W-1:0] en_q;
  logic [REG_W-1:0] rd_next;

  assign pick = reg_pick_e'(addr_i[2]);

  // Enable register: only wired positions have storage
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      en_q <= '0;
    end else if (sel_i && wr_i && pick == REG_ENABLE) begin
      en_q <= wdata_i[SRC_W-1:0] & KEEP_MASK;
    end
  end

  always_comb begin
    rd_next = '0;
    unique case (pick)
      REG_ENABLE: rd_next[SRC_W-1:0] = en_q;
      REG_STATUS: rd_next[SRC_W-1:0] = src_i & KEEP_MASK;
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= sel_i && !wr_i;
      if (sel_i && !wr_i) rdata_o <= rd_next;
    end
  end

  assign en_o = en_q;

endmodule

// File: rtl/l2irq_route.sv
module l2irq_route #(
  parameter int unsigned                     SRC_W     = 32,
  parameter int unsigned                     NUM_AGG   = 2,
  parameter logic [NUM_AGG-1:0][SRC_W-1:0]   AGG_MASKS = '0,
  parameter logic [SRC_W-1:0]                FWD_MASK  = '0
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [SRC_W-1:0]   src_i,
  input  logic [SRC_W-1:0]   en_i,
  output logic [SRC_W-1:0]   pend_o,
  output logic [NUM_AGG-1:0] agg_o,
  output logic [SRC_W-1:0]   fwd_o
);

  localparam logic [SRC_W-1:0] KEEP_OUT = ~FWD_MASK;

  logic [SRC_W-1:0]   live;
  logic [NUM_AGG-1:0] agg_d;
  logic [SRC_W-1:0]   fwd_d;

  // Sources still handled locally, gated by enable
  assign live   = src_i & en_i & KEEP_OUT;
  assign pend_o = live;

  for (genvar k = 0; k < NUM_AGG; k++) begin : g_agg
    localparam logic [SRC_W-1:0] SEL = AGG_MASKS[k] & KEEP_OUT;
    assign agg_d[k] = |(live & SEL);
  end

  // Per-source bypass gate
  for (genvar i = 0; i < SRC_W; i++) begin : g_fwd
    if (FWD_MASK[i]) begin : g_on
      assign fwd_d[i] = src_i[i];
    end else begin : g_off
      assign fwd_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      agg_o <= '0;
      fwd_o <= '0;
    end else begin
      agg_o <= agg_d;
      fwd_o <= fwd_d;
    end
  end

endmodule

// File: rtl/l2irq_wake.sv
module l2irq_wake #(
  parameter int unsigned      SRC_W     = 32,
  parameter bit               WAKE_EN   = 1'b1,
  parameter logic [SRC_W-1:0] WAKE_MASK = '1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [SRC_W-1:0] pend_i,
  output logic             wake_o
);

  if (WAKE_EN) begin : g_wake
    logic wake_q;
    always_ff @(posedge clk_i) begin
      if (rst_i) wake_q <= 1'b0;
      else       wake_q <= |(pend_i & WAKE_MASK);
    end
    assign wake_o = wake_q;
  end else begin : g_nowake
    logic unused;
    assign unused = clk_i ^ rst_i ^ (|pend_i);
    assign wake_o = 1'b0;
  end

endmodule

// File: rtl/l2_irq_aggregator.sv
module l2_irq_aggregator
  import l2irq_pkg::*;
#(
  parameter int unsigned                   SRC_W     = 32,
  parameter int unsigned                   NUM_AGG   = 2,
  parameter logic [NUM_AGG-1:0][SRC_W-1:0] AGG_MASKS = {32'h0000_0140, 32'h0000_0EB8},
  parameter logic [SRC_W-1:0]              FWD_MASK  = 32'h0000_0007,
  parameter bit                            WAKE_EN   = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [SRC_W-1:0]   src_i,
  input  logic               reg_sel_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  output logic               reg_rvalid_o,
  output logic [NUM_AGG-1:0] agg_irq_o,
  output logic [SRC_W-1:0]   fwd_irq_o,
  output logic               wake_o
);

  function automatic logic [SRC_W-1:0] map_union();
    logic [SRC_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < NUM_AGG; k++) acc = acc | AGG_MASKS[k];
    return acc;
  endfunction

  localparam logic [SRC_W-1:0] MAPPED = map_union();
  localparam logic [SRC_W-1:0] WIRED  = MAPPED | FWD_MASK;

  logic [SRC_W-1:0] enable_q;
  logic [SRC_W-1:0] pend;

  l2irq_regs #(
    .SRC_W     (SRC_W),
    .KEEP_MASK (WIRED)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .sel_i    (reg_sel_i),
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .src_i    (src_i),
    .en_o     (enable_q),
    .rdata_o  (reg_rdata_o),
    .rvalid_o (reg_rvalid_o)
  );

  l2irq_route #(
    .SRC_W     (SRC_W),
    .NUM_AGG   (NUM_AGG),
    .AGG_MASKS (AGG_MASKS),
    .FWD_MASK  (FWD_MASK)
  ) u_route (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .src_i  (src_i),
    .en_i   (enable_q),
    .pend_o (pend),
    .agg_o  (agg_irq_o),
    .fwd_o  (fwd_irq_o)
  );

  l2irq_wake #(
    .SRC_W     (SRC_W),
    .WAKE_EN   (WAKE_EN),
    .WAKE_MASK (MAPPED)
  ) u_wake (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .pend_i (pend),
    .wake_o (wake_o)
  );

endmodule

// File: rtl/l2irq_checker.sv
module l2irq_checker #(
  parameter int unsigned                   SRC_W     = 32,
  parameter int unsigned                   NUM_AGG   = 2,
  parameter logic [NUM_AGG-1:0][SRC_W-1:0] AGG_MASKS = '0,
  parameter logic [SRC_W-1:0]              FWD_MASK  = '0,
  parameter bit                            WAKE_EN   = 1'b1
) (
  input logic               clk_i,
  input logic               rst_i,
  input logic [SRC_W-1:0]   src_i,
  input logic               reg_sel_i,
  input logic               reg_wr_i,
  input logic [SRC_W-1:0]   enable_q,
  input logic               reg_rvalid_o,
  input logic [NUM_AGG-1:0] agg_irq_o,
  input logic [SRC_W-1:0]   fwd_irq_o,
  input logic               wake_o
);

  logic primed;
  logic [SRC_W-1:0] mapped;

  always_comb begin
    mapped = '0;
    for (int k = 0; k < NUM_AGG; k++) mapped = mapped | AGG_MASKS[k];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  // R3: bits outside the forward mask stay low
  a_r3_fwd_unused_low: assert property (@(posedge clk_i) disable iff (rst_i)
    (fwd_irq_o & ~FWD_MASK) == '0);

  // R3: forwarded lines follow their source one cycle later
  a_r3_fwd_follows: assert property (@(posedge clk_i) disable iff (rst_i || !primed)
    fwd_irq_o == ($past(src_i) & FWD_MASK));

  // R2 and R4: merged lines track enabled, non-forwarded sources
  for (genvar k = 0; k < NUM_AGG; k++) begin : g_chk
    a_r2_agg_or: assert property (@(posedge clk_i) disable iff (rst_i || !primed)
      agg_irq_o[k] == |($past(src_i) & $past(enable_q) & AGG_MASKS[k] & ~FWD_MASK));
  end

  // R8: wake request
  a_r8_wake: assert property (@(posedge clk_i) disable iff (rst_i || !primed)
    wake_o == (WAKE_EN && |($past(src_i) & $past(enable_q) & mapped & ~FWD_MASK)));

  // R7: read strobe one cycle after a read request
  a_r7_rvalid: assert property (@(posedge clk_i) disable iff (rst_i || !primed)
    reg_rvalid_o == $past(reg_sel_i && !reg_wr_i));

  // R1: unwired enable bits never stored
  a_r1_enable_unwired: assert property (@(posedge clk_i) disable iff (rst_i)
    (enable_q & ~(mapped | FWD_MASK)) == '0);

endmodule

bind l2_irq_aggregator l2irq_checker #(
  .SRC_W     (SRC_W),
  .NUM_AGG   (NUM_AGG),
  .AGG_MASKS (AGG_MASKS),
  .FWD_MASK  (FWD_MASK),
  .WAKE_EN   (WAKE_EN)
) u_chk (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .src_i        (src_i),
  .reg_sel_i    (reg_sel_i),
  .reg_wr_i     (reg_wr_i),
  .enable_q     (enable_q),
  .reg_rvalid_o (reg_rvalid_o),
  .agg_irq_o    (agg_irq_o),
  .fwd_irq_o    (fwd_irq_o),
  .wake_o       (wake_o)
);

// File: tb/l2_irq_aggregator_test.sv
`timescale 1ns/1ps
module l2_irq_aggregator_test;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] src;
  logic        sel, wr;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        rvalid;
  logic [1:0]  agg;
  logic [31:0] fwd;
  logic        wake;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  l2_irq_aggregator #(
    .SRC_W     (32),
    .NUM_AGG   (2),
    .AGG_MASKS ({32'h0000_0141, 32'h0000_0EB8}),
    .FWD_MASK  (32'h0000_0007),
    .WAKE_EN   (1'b1)
  ) uut (
    .clk_i        (clk),
    .rst_i        (rst),
    .src_i        (src),
    .reg_sel_i    (sel),
    .reg_wr_i     (wr),
    .reg_addr_i   (addr),
    .reg_wdata_i  (wdata),
    .reg_rdata_o  (rdata),
    .reg_rvalid_o (rvalid),
    .agg_irq_o    (agg),
    .fwd_irq_o    (fwd),
    .wake_o       (wake)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    step();
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, input string req, input logic [31:0] exp);
    sel = 1'b1; wr = 1'b0; addr = a;
    step();
    sel = 1'b0;
    check({req, " rvalid"}, {31'd0, rvalid}, 32'd1);
    check(req, rdata, exp);
  endtask

  task automatic apply(input logic [31:0] s);
    src = s;
    step();
  endtask

  task automatic t_reset();
    rst = 1'b1; src = 32'h0000_0FFF; sel = 0; wr = 0; addr = 0; wdata = 0;
    step(); step();
    check("R10 agg", {30'd0, agg}, 32'd0);
    check("R10 fwd", fwd, 32'd0);
    check("R10 wake", {31'd0, wake}, 32'd0);
    rst = 1'b0; src = 32'd0;
    step();
    check("R7 no read no rvalid", {31'd0, rvalid}, 32'd0);
    reg_read(3'h0, "R10 enable after reset", 32'd0);
  endtask

  task automatic t_enable_rw();
    reg_write(3'h0, 32'hFFFF_FFFF);
    reg_read(3'h0, "R5 R1 enable readback", 32'h0000_0FFF);
  endtask

  task automatic t_merge();
    apply(32'h0000_0010);
    check("R2 map0 src4", {30'd0, agg}, 32'd1);
    check("R8 wake src4", {31'd0, wake}, 32'd1);
    apply(32'h0000_0140);
    check("R2 map1 src6 src8", {30'd0, agg}, 32'd2);
    apply(32'h0000_0848);
    check("R2 both maps", {30'd0, agg}, 32'd3);
  endtask

  task automatic t_forward();
    apply(32'h0000_0001);
    check("R4 fwd src0 hidden from map1", {30'd0, agg}, 32'd0);
    check("R4 fwd src0 no wake", {31'd0, wake}, 32'd0);
    check("R3 fwd src0 direct", fwd, 32'h0000_0001);
    reg_write(3'h0, 32'd0);
    apply(32'h0000_0007);
    check("R3 fwd ignores enable", fwd, 32'h0000_0007);
    check("R2 disabled merged quiet", {30'd0, agg}, 32'd0);
    reg_write(3'h0, 32'h0000_0FFF);
  endtask

  task automatic t_unwired();
    apply(32'hFFFF_F000);
    check("R1 unwired agg", {30'd0, agg}, 32'd0);
    check("R1 unwired fwd", fwd, 32'd0);
    check("R1 unwired wake", {31'd0, wake}, 32'd0);
    reg_read(3'h4, "R1 unwired status", 32'd0);
  endtask

  task automatic t_status();
    src = 32'hFFFF_FA5A;
    reg_read(3'h4, "R6 status levels", 32'h0000_0A5A);
    reg_write(3'h4, 32'd0);
    reg_read(3'h0, "R6 status write ignored", 32'h0000_0FFF);
  endtask

  task automatic t_drop();
    apply(32'h0000_0018);
    check("R9 two contributors", {30'd0, agg}, 32'd1);
    apply(32'h0000_0010);
    check("R9 one left still high", {30'd0, agg}, 32'd1);
    apply(32'h0000_0000);
    check("R9 last dropped", {30'd0, agg}, 32'd0);
    src = 32'h0000_0010;
    step();
    check("R9 re-raised", {30'd0, agg}, 32'd1);
    reg_write(3'h0, 32'h0000_0FEF);
    check("R9 old enable in write cycle", {30'd0, agg}, 32'd1);
    step();
    check("R9 disabled drops", {30'd0, agg}, 32'd0);
    check("R8 disabled no wake", {31'd0, wake}, 32'd0);
  endtask

  task automatic t_reset_mid();
    reg_write(3'h0, 32'h0000_0FFF);
    apply(32'h0000_0157);
    check("R2 pre-reset active", {30'd0, agg}, 32'd3);
    rst = 1'b1;
    step();
    check("R10 mid reset agg", {30'd0, agg}, 32'd0);
    check("R10 mid reset fwd", fwd, 32'd0);
    rst = 1'b0; src = 32'd0;
    step();
    reg_read(3'h0, "R10 mid reset enable", 32'd0);
  endtask

  initial begin
    t_reset();
    t_enable_rw();
    t_merge();
    t_forward();
    t_unwired();
    t_status();
    t_drop();
    t_reset_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule